// File: doc/BRIEF.md
# Ambiguity-Triggered Re-Inference Controller

This block follows the readout stage of a binary inference array. It takes one accumulated score per output class and ranks them to find the leading class and the runner-up. It then tests whether the lead over the runner-up is large enough, measured as a percentage of the leading score. If the lead is large enough, the leading class is reported straight away.

If the lead is too small, the block reads one mask word from a small external table. The table address is fixed by the unordered pair of confused classes. The block then asks the array for a single second pass with that mask driving the per-row modulation. When the second pass returns, only the two confused classes are compared, and the larger one is reported. Stored weights are never rewritten. At most one second pass happens per score vector.

The controller takes one job at a time. A new score vector is accepted only after the result of the previous one has been presented.

Top module: `amb_reread_ctrl`

## Requirements
- R1: `in_ready` is high only while the controller is idle. After a vector is accepted, `in_ready` stays low until the cycle after the one-cycle `res_valid` pulse.
- R2: The leading class is the one with the largest score. Equal scores go to the lower index, and the runner-up is chosen the same way among the other classes. When no second pass is needed, `res_valid` rises two cycles after the accepting edge, with `res_class` set to the leading class and both `res_uncertain` and `res_reread` low.
- R3: With scores and `margin_pct` taken at the accepting edge, a result is ambiguous exactly when (lead − runner-up) × 100 < margin_pct × lead. Equality counts as not ambiguous, and margin_pct = 0 never triggers.
- R4: On ambiguity, `tbl_rd` pulses for one cycle. `tbl_addr` is lo×N − lo×(lo+1)/2 + (hi − lo − 1), where lo < hi are the two confused classes, so both orderings share one entry. `tbl_data` must be valid the cycle after the pulse.
- R5: Bit r of `rr_mask` steers input row r: 1 means potentiate and 0 means depress. `rr_mask` equals the fetched table word. `rr_req` holds high with `rr_mask` stable until the cycle where `rr_ack` is sampled high.
- R6: Each accepted vector causes at most one table read and at most one second-pass request. A clear result causes neither.
- R7: After the second pass, only the second-pass scores of the two confused classes are compared, and the larger one is reported with `res_reread` high and `res_uncertain` low. Scores of all other classes have no effect.
- R8: If the two second-pass scores are equal, the lower class index of the pair is reported with `res_uncertain` high.
- R9: After reset, `in_ready` is high and `res_valid`, `tbl_rd` and `rr_req` are low.
- R10: `in_valid` asserted while the controller is busy is not accepted and does not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Score vector valid |
| in_ready | output | 1 | Controller idle and able to accept |
| in_scores | input | N_CLASS×SCORE_W | Score vector; class i in bits [i×SCORE_W +: SCORE_W] |
| margin_pct | input | PCT_W | Margin threshold in percent, sampled on accept |
| tbl_rd | output | 1 | Mask table read strobe |
| tbl_addr | output | PAIR_W | Class-pair table address |
| tbl_data | input | N_ROW | Mask word, valid one cycle after the strobe |
| rr_req | output | 1 | Second-pass request |
| rr_mask | output | N_ROW | Per-row modulation mask for the second pass |
| rr_ack | input | 1 | Second-pass scores valid |
| rr_scores | input | N_CLASS×SCORE_W | Second-pass scores, same layout as in_scores |
| res_valid | output | 1 | Result pulse |
| res_class | output | CLS_W | Reported class |
| res_uncertain | output | 1 | Second-pass tie left unresolved |
| res_reread | output | 1 | Result came from a second pass |

## Verification
Random score vectors are run in two kinds. In the first kind, two classes are pushed close together so that the margin test lands on both sides. The second kind is spread out, which gives mostly clear wins and shows that the fast path skips the table and the array. Directed vectors place the lead exactly on the percentage boundary and one count inside it. They also tie the leading scores and use all-zero scores and a zero threshold. These cases separate a strict from a non-strict comparison and check the lower-index tie rule. Second-pass responses are chosen so that a third class has the highest score, so that the confused pair ties, and so that the pair arrives in both orders. These cases show that only the pair is compared and that the table index does not depend on order. Busy-time `in_valid` pulses and delayed acknowledges test the one-job-at-a-time and hold-until-ack behaviour.

// File: rtl/amb_pkg.sv
package amb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_EVAL   = 3'd1,
        ST_LOOKUP = 3'd2,
        ST_REREAD = 3'd3,
        ST_DONE   = 3'd4
    } ctl_state_e;

    // Triangular slot of the unordered pair (lo, hi), lo < hi, among n classes.
    function automatic int pair_slot(input int lo, input int hi, input int n);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

endpackage

// File: rtl/amb_top2.sv
module amb_top2 #(
    parameter int N_CLASS = 10,
    parameter int SCORE_W = 16,
    localparam int CLS_W  = $clog2(N_CLASS)
) (
    input  logic [N_CLASS*SCORE_W-1:0] scores,
    output logic [CLS_W-1:0]           lead_idx,
    output logic [SCORE_W-1:0]         lead_val,
    output logic [CLS_W-1:0]           run_idx,
    output logic [SCORE_W-1:0]         run_val
);
    // Single pass; strict compares keep the lower index on equal scores.
    always_comb begin
        logic [SCORE_W-1:0] cur;
        lead_val = scores[SCORE_W-1:0];
        lead_idx = '0;
        run_val  = '0;
        run_idx  = '0;
        for (int i = 1; i < N_CLASS; i++) begin
            cur = scores[i*SCORE_W +: SCORE_W];
            if (cur > lead_val) begin
                run_val  = lead_val;
                run_idx  = lead_idx;
                lead_val = cur;
                lead_idx = CLS_W'(i);
            end else if ((i == 1) || (cur > run_val)) begin
                run_val = cur;
                run_idx = CLS_W'(i);
            end
        end
    end
endmodule

// File: rtl/amb_margin_chk.sv
module amb_margin_chk #(
    parameter int SCORE_W = 16,
    parameter int PCT_W   = 7,
    localparam int PW     = SCORE_W + ((PCT_W > 7) ? PCT_W : 7) + 1
) (
    input  logic [SCORE_W-1:0] lead_val,
    input  logic [SCORE_W-1:0] run_val,
    input  logic [PCT_W-1:0]   pct,
    output logic               ambiguous
);
    logic [PW-1:0] gap_scaled;
    logic [PW-1:0] limit;

    always_comb begin
        gap_scaled = PW'(lead_val - run_val) * PW'(100);
        limit      = PW'(lead_val) * PW'(pct);
        ambiguous  = gap_scaled < limit;
    end
endmodule

// File: rtl/amb_pair_map.sv
module amb_pair_map #(
    parameter int N_CLASS = 10,
    localparam int CLS_W  = $clog2(N_CLASS),
    localparam int N_PAIR = N_CLASS * (N_CLASS - 1) / 2,
    localparam int PAIR_W = $clog2(N_PAIR)
) (
    input  logic [CLS_W-1:0]  cls_a,
    input  logic [CLS_W-1:0]  cls_b,
    output logic [PAIR_W-1:0] slot
);
    logic [CLS_W-1:0] lo;
    logic [CLS_W-1:0] hi;

    always_comb begin
        if (cls_a < cls_b) begin
            lo = cls_a;
            hi = cls_b;
        end else begin
            lo = cls_b;
            hi = cls_a;
        end
        slot = PAIR_W'(amb_pkg::pair_slot(int'(lo), int'(hi), N_CLASS));
    end
endmodule

// File: rtl/amb_reread_ctrl.sv
module amb_reread_ctrl
    import amb_pkg::*;
#(
    parameter int N_CLASS = 10,
    parameter int N_ROW   = 64,
    parameter int SCORE_W = 16,
    parameter int PCT_W   = 7,
    localparam int CLS_W  = $clog2(N_CLASS),
    localparam int N_PAIR = N_CLASS * (N_CLASS - 1) / 2,
    localparam int PAIR_W = $clog2(N_PAIR),
    localparam int VEC_W  = N_CLASS * SCORE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VEC_W-1:0]  in_scores,
    input  logic [PCT_W-1:0]  margin_pct,
    output logic              tbl_rd,
    output logic [PAIR_W-1:0] tbl_addr,
    input  logic [N_ROW-1:0]  tbl_data,
    output logic              rr_req,
    output logic [N_ROW-1:0]  rr_mask,
    input  logic              rr_ack,
    input  logic [VEC_W-1:0]  rr_scores,
    output logic              res_valid,
    output logic [CLS_W-1:0]  res_class,
    output logic              res_uncertain,
    output logic              res_reread
);
    ctl_state_e         state_q;
    logic [VEC_W-1:0]   scores_q;
    logic [PCT_W-1:0]   pct_q;
    logic [CLS_W-1:0]   lead_q, run_q;
    logic               fetch_wait_q;
    logic [N_ROW-1:0]   mask_q;
    logic [CLS_W-1:0]   cls_q;
    logic               unc_q, rr_done_q;

    logic [CLS_W-1:0]   lead_idx, run_idx;
    logic [SCORE_W-1:0] lead_val, run_val;
    logic               ambiguous;
    logic [SCORE_W-1:0] rr_lead, rr_run;
    logic [CLS_W-1:0]   pair_lo;

    amb_top2 #(.N_CLASS(N_CLASS), .SCORE_W(SCORE_W)) u_rank (
        .scores   (scores_q),
        .lead_idx (lead_idx),
        .lead_val (lead_val),
        .run_idx  (run_idx),
        .run_val  (run_val)
    );

    amb_margin_chk #(.SCORE_W(SCORE_W), .PCT_W(PCT_W)) u_margin (
        .lead_val  (lead_val),
        .run_val   (run_val),
        .pct       (pct_q),
        .ambiguous (ambiguous)
    );

    amb_pair_map #(.N_CLASS(N_CLASS)) u_pair (
        .cls_a (lead_q),
        .cls_b (run_q),
        .slot  (tbl_addr)
    );

    assign rr_lead = rr_scores[lead_q*SCORE_W +: SCORE_W];
    assign rr_run  = rr_scores[run_q*SCORE_W +: SCORE_W];
    assign pair_lo = (lead_q < run_q) ? lead_q : run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            scores_q     <= '0;
            pct_q        <= '0;
            lead_q       <= '0;
            run_q        <= '0;
            fetch_wait_q <= 1'b0;
            mask_q       <= '0;
            cls_q        <= '0;
            unc_q        <= 1'b0;
            rr_done_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        scores_q <= in_scores;
                        pct_q    <= margin_pct;
                        state_q  <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    lead_q <= lead_idx;
                    run_q  <= run_idx;
                    if (ambiguous) begin
                        fetch_wait_q <= 1'b0;
                        state_q      <= ST_LOOKUP;
                    end else begin
                        cls_q     <= lead_idx;
                        unc_q     <= 1'b0;
                        rr_done_q <= 1'b0;
                        state_q   <= ST_DONE;
                    end
                end
                ST_LOOKUP: begin
                    if (!fetch_wait_q) begin
                        fetch_wait_q <= 1'b1;
                    end else begin
                        mask_q  <= tbl_data;
                        state_q <= ST_REREAD;
                    end
                end
                ST_REREAD: begin
                    if (rr_ack) begin
                        rr_done_q <= 1'b1;
                        if (rr_lead > rr_run) begin
                            cls_q <= lead_q;
                            unc_q <= 1'b0;
                        end else if (rr_run > rr_lead) begin
                            cls_q <= run_q;
                            unc_q <= 1'b0;
                        end else begin
                            cls_q <= pair_lo;
                            unc_q <= 1'b1;
                        end
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_ready      = (state_q == ST_IDLE);
    assign tbl_rd        = (state_q == ST_LOOKUP) && !fetch_wait_q;
    assign rr_req        = (state_q == ST_REREAD);
    assign rr_mask       = mask_q;
    assign res_valid     = (state_q == ST_DONE);
    assign res_class     = cls_q;
    assign res_uncertain = unc_q;
    assign res_reread    = rr_done_q;
endmodule

// File: rtl/amb_reread_ctrl_chk.sv
module amb_reread_ctrl_chk #(
    parameter int N_CLASS = 10,
    parameter int N_ROW   = 64,
    localparam int CLS_W  = $clog2(N_CLASS),
    localparam int N_PAIR = N_CLASS * (N_CLASS - 1) / 2,
    localparam int PAIR_W = $clog2(N_PAIR)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              tbl_rd,
    input logic [PAIR_W-1:0] tbl_addr,
    input logic              rr_req,
    input logic [N_ROW-1:0]  rr_mask,
    input logic              rr_ack,
    input logic              res_valid,
    input logic [CLS_W-1:0]  res_class,
    input logic              res_uncertain,
    input logic              res_reread
);
    logic seen_rd_q, seen_rr_q;

    always_ff @(posedge clk) begin
        if (rst || (in_valid && in_ready)) begin
            seen_rd_q <= 1'b0;
            seen_rr_q <= 1'b0;
        end else begin
            if (tbl_rd) seen_rd_q <= 1'b1;
            if (rr_req && rr_ack) seen_rr_q <= 1'b1;
        end
    end

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    a_r1_result_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (!res_valid && in_ready));
    a_r1_result_blocks_ready: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !in_ready);
    a_r2_clear_is_certain: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_reread) |-> !res_uncertain);
    a_r4_read_pulse: assert property (@(posedge clk) disable iff (rst)
        tbl_rd |=> !tbl_rd);
    a_r4_addr_range: assert property (@(posedge clk) disable iff (rst)
        tbl_rd |-> (int'(tbl_addr) < N_PAIR));
    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (rr_req && !rr_ack) |=> (rr_req && $stable(rr_mask)));
    a_r6_one_table_read: assert property (@(posedge clk) disable iff (rst)
        tbl_rd |-> !seen_rd_q);
    a_r6_one_reread: assert property (@(posedge clk) disable iff (rst)
        rr_req |-> (!seen_rr_q && seen_rd_q));
    a_r7_reread_result_class: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((int'(res_class) < N_CLASS) && (res_reread == seen_rr_q)));
    a_r8_uncertain_needs_reread: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_uncertain) |-> res_reread);
endmodule

bind amb_reread_ctrl amb_reread_ctrl_chk #(
    .N_CLASS (N_CLASS),
    .N_ROW   (N_ROW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .tbl_rd        (tbl_rd),
    .tbl_addr      (tbl_addr),
    .rr_req        (rr_req),
    .rr_mask       (rr_mask),
    .rr_ack        (rr_ack),
    .res_valid     (res_valid),
    .res_class     (res_class),
    .res_uncertain (res_uncertain),
    .res_reread    (res_reread)
);

// File: tb/amb_reread_ctrl_tb.sv
module amb_reread_ctrl_tb;
    localparam int N      = 10;
    localparam int ROWS   = 64;
    localparam int W      = 16;
    localparam int PW     = 7;
    localparam int CW     = $clog2(N);
    localparam int NP     = N * (N - 1) / 2;
    localparam int AW     = $clog2(NP);

    typedef int vec_t[N];

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [N*W-1:0]    in_scores = '0;
    logic [PW-1:0]     margin_pct = '0;
    logic              tbl_rd;
    logic [AW-1:0]     tbl_addr;
    logic [ROWS-1:0]   tbl_data = '0;
    logic              rr_req;
    logic [ROWS-1:0]   rr_mask;
    logic              rr_ack = 1'b0;
    logic [N*W-1:0]    rr_scores = '0;
    logic              res_valid;
    logic [CW-1:0]     res_class;
    logic              res_uncertain;
    logic              res_reread;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    amb_reread_ctrl u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_scores(in_scores), .margin_pct(margin_pct), .tbl_rd(tbl_rd),
        .tbl_addr(tbl_addr), .tbl_data(tbl_data), .rr_req(rr_req),
        .rr_mask(rr_mask), .rr_ack(rr_ack), .rr_scores(rr_scores),
        .res_valid(res_valid), .res_class(res_class),
        .res_uncertain(res_uncertain), .res_reread(res_reread)
    );

    function automatic logic [ROWS-1:0] mask_of(input int a);
        logic [31:0] h1, h2;
        h1 = 32'(a) * 32'h9E3779B9 + 32'h1234;
        h2 = ~(32'(a) * 32'h85EBCA6B);
        return {h1, h2};
    endfunction

    // Table memory model: one-cycle read latency.
    always @(posedge clk) if (tbl_rd) tbl_data <= mask_of(int'(tbl_addr));

    function automatic logic [N*W-1:0] pack(input vec_t s);
        logic [N*W-1:0] p;
        for (int i = 0; i < N; i++) p[i*W +: W] = W'(s[i]);
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_job(input vec_t sc, input int pct, input vec_t rsc,
                           input int ack_dly, input bit junk);
        int t, u, lo, hi, addr, exp_cls, cyc, nrd, nrr, wait_n;
        bit amb, exp_unc, got, ack_sent, prev_rr;
        vec_t jk;
        t = 0;
        for (int i = 0; i < N; i++) if (sc[i] > sc[t]) t = i;
        u = -1;
        for (int i = 0; i < N; i++) if (i != t && (u < 0 || sc[i] > sc[u])) u = i;
        amb = (longint'(sc[t] - sc[u]) * 100) < (longint'(pct) * sc[t]);
        lo = (t < u) ? t : u;
        hi = (t < u) ? u : t;
        addr = lo * N - (lo * (lo + 1)) / 2 + (hi - lo - 1);
        if (!amb) begin
            exp_cls = t; exp_unc = 1'b0;
        end else if (rsc[t] > rsc[u]) begin
            exp_cls = t; exp_unc = 1'b0;
        end else if (rsc[u] > rsc[t]) begin
            exp_cls = u; exp_unc = 1'b0;
        end else begin
            exp_cls = lo; exp_unc = 1'b1;
        end
        for (int i = 0; i < N; i++) jk[i] = (i == 0) ? 5000 : 0;

        @(negedge clk);
        chk(in_ready == 1'b1, "R1 ready before accept", in_ready, 1);
        in_valid   = 1'b1;
        in_scores  = pack(sc);
        margin_pct = PW'(pct);
        @(negedge clk);
        in_valid = junk;
        if (junk) begin
            in_scores  = pack(jk);
            margin_pct = PW'(99);
        end
        cyc = 1; nrd = 0; nrr = 0; wait_n = ack_dly;
        got = 1'b0; ack_sent = 1'b0; prev_rr = 1'b0;
        while (cyc < 200) begin
            if (rr_ack) rr_ack = 1'b0;
            if (tbl_rd) begin
                nrd++;
                chk(int'(tbl_addr) == addr, "R4 table address", tbl_addr, addr);
            end
            if (rr_req) begin
                if (!prev_rr) nrr++;
                chk(rr_mask == mask_of(addr), "R5 mask word", 0, 0);
                if (!ack_sent) begin
                    if (wait_n == 0) begin
                        rr_scores = pack(rsc);
                        rr_ack    = 1'b1;
                        ack_sent  = 1'b1;
                    end else begin
                        wait_n--;
                    end
                end
            end
            prev_rr = rr_req;
            if (res_valid) begin
                in_valid = 1'b0;
                got = 1'b1;
                break;
            end
            @(negedge clk);
            cyc++;
        end
        chk(got, "R1 result produced", got, 1);
        if (!amb) begin
            chk(cyc == 2, "R2 clear latency", cyc, 2);
            chk(nrd == 0 && nrr == 0, "R6 no fetch on clear", nrd + nrr, 0);
            chk(res_reread == 1'b0, "R2 reread flag", res_reread, 0);
        end else begin
            chk(nrd == 1, "R6 one table read", nrd, 1);
            chk(nrr == 1, "R6 one reread", nrr, 1);
            chk(res_reread == 1'b1, "R7 reread flag", res_reread, 1);
        end
        chk(int'(res_class) == exp_cls, amb ? "R7 reread class" : "R2 class",
            res_class, exp_cls);
        chk(res_uncertain == exp_unc, "R8 uncertain flag", res_uncertain, exp_unc);
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 result is a pulse", res_valid, 0);
        chk(in_ready == 1'b1, junk ? "R10 busy input ignored" : "R1 ready again",
            in_ready, 1);
    endtask

    task automatic zero(output vec_t v);
        for (int i = 0; i < N; i++) v[i] = 0;
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t s, r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 reset ready", in_ready, 1);
        chk(!res_valid && !tbl_rd && !rr_req, "R9 reset outputs", res_valid, 0);

        // R3 boundary: 5% exactly met -> clear
        zero(s); zero(r); s[3] = 100; s[7] = 95;
        run_job(s, 5, r, 0, 1'b0);
        // R3 one count inside -> ambiguous; R7 third class high ignored
        zero(s); zero(r); s[3] = 100; s[7] = 96; r[7] = 500; r[3] = 400; r[0] = 999;
        run_job(s, 5, r, 0, 1'b0);
        // R8 tie on second pass, pair (0,9)
        zero(s); zero(r); s[9] = 200; s[0] = 199; r[9] = 300; r[0] = 300;
        run_job(s, 5, r, 1, 1'b0);
        // R4 reversed order, same slot
        zero(s); zero(r); s[0] = 200; s[9] = 199; r[9] = 301; r[0] = 300; r[5] = 900;
        run_job(s, 5, r, 2, 1'b0);
        // R3 all zero, R2 lower index
        zero(s); zero(r);
        run_job(s, 50, r, 0, 1'b0);
        // R2 equal leaders 2 and 5
        zero(s); zero(r); s[5] = 700; s[2] = 700; r[2] = 10; r[5] = 20;
        run_job(s, 1, r, 0, 1'b0);
        // R3 zero threshold never triggers
        zero(s); zero(r); s[4] = 10; s[8] = 9;
        run_job(s, 0, r, 0, 1'b0);
        // R10 busy input with delayed acknowledge
        zero(s); zero(r); s[6] = 400; s[1] = 399; r[1] = 50; r[6] = 40;
        run_job(s, 10, r, 3, 1'b1);

        for (int k = 0; k < 60; k++) begin
            int a, b;
            for (int i = 0; i < N; i++) begin
                s[i] = int'($urandom_range(0, 900));
                r[i] = int'($urandom_range(0, 999));
            end
            if ($urandom_range(0, 2) != 0) begin
                a = int'($urandom_range(0, N - 1));
                b = (a + 1 + int'($urandom_range(0, N - 2))) % N;
                s[a] = 950 + int'($urandom_range(0, 40));
                s[b] = s[a] - int'($urandom_range(0, 60));
                if ($urandom_range(0, 3) == 0) r[a] = r[b];
            end
            run_job(s, int'($urandom_range(1, 10)), r,
                    int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule